// File: doc/BRIEF.md
# Bitstream Header Clock-to-Data Ratio Selector

This block sits beside the configuration word stream of a programmable-logic loader. It watches the leading 32-bit words of each image and picks up two flags at fixed header positions. One flag says whether the image is encrypted. The other says whether it is compressed. It then combines the two flags with the configuration bus width and produces the 2-bit clock-to-data ratio code that the configuration clock generator needs.

A start-of-image pulse arms the block and samples the width select. The block counts accepted words from then on and settles once the last header word it needs has gone by. The code is then held with a valid flag until the next image starts. An image that ends before that word arrives raises a short-header error instead.

Top module: `cdr_hdr_top`

## Requirements
- R1: After reset, ratioValid and headerShort are 0 and ratioCode is 0.
- R2: The image is encrypted when bits [3:2] of accepted word index 69 (counted from 0) are nonzero. Values 1, 2 and 3 all count as encrypted.
- R3: The image is compressed when bit 1 of accepted word index 229 is 0. When that bit is 1, the image is not compressed.
- R4: Code values are 0 for x1, 1 for x2, 2 for x4 and 3 for x8. With neither flag set, the code is 0 for both widths.
- R5: With 16-bit width, encrypted-only gives code 1, and compressed (with or without encryption) gives code 2.
- R6: With 32-bit width, encrypted-only gives code 2, and compressed (with or without encryption) gives code 3.
- R7: wideSel is sampled only in the start-of-image cycle (1 = 32-bit, 0 = 16-bit). Later changes to it have no effect on the code.
- R8: ratioValid rises in the cycle right after word 229 is accepted. It then stays high, with ratioCode unchanged, until the next sofPulse.
- R9: If wordLast comes with an accepted word whose index is below 229, headerShort is 1 from the next cycle until the next sofPulse. ratioValid stays 0 and ratioCode reads 0. An image of exactly 230 words is not short.
- R10: Some words are not accepted and have no effect: words with wordValid low (their wordLast too), a word in the sofPulse cycle, words before the first sofPulse, and words after the decision.
- R11: A sofPulse clears ratioValid and headerShort from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofPulse | input | 1 | Start-of-image pulse; restarts the word count |
| wideSel | input | 1 | Bus width select, sampled with sofPulse (1 = 32-bit) |
| wordValid | input | 1 | A stream word is present this cycle |
| wordLast | input | 1 | The present word is the last of the image |
| wordData | input | 32 | Stream word |
| ratioCode | output | 2 | Clock-to-data ratio code (0 when not valid) |
| ratioValid | output | 1 | ratioCode is settled for this image |
| headerShort | output | 1 | Image ended before the header was complete |

## Verification
The bench drives whole images across all eight width and flag combinations and checks the cycle in which the result appears. A counter that is off by one would sample the wrong header word and report a late or early rise. Idle gaps carry garbage data and a stray last flag; a design that counted them would pick up wrong flags or end the image too soon. Images of 229 and 230 words probe the short-header boundary, and a wrong comparison there flags a legal image as short. A word sent alongside sofPulse, and width changes after the pulse, catch a design that counts the pulse word or follows the live width input.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_DONE    = 2'd2,
    ST_SHORT   = 2'd3
  } hdrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // new image: drop flags, sample width
    logic capEnc;  // present word holds the encryption field
    logic capCmp;  // present word holds the decompression bit
  } hdrStrobe_t;

  localparam logic [1:0] RATIO_X1 = 2'd0;
  localparam logic [1:0] RATIO_X2 = 2'd1;
  localparam logic [1:0] RATIO_X4 = 2'd2;
  localparam logic [1:0] RATIO_X8 = 2'd3;

  function automatic logic [1:0] calcRatio(input logic enc, input logic cmp, input logic wide);
    logic [1:0] base;
    if (!enc && !cmp) begin
      base = RATIO_X1;
    end else begin
      base = cmp ? RATIO_X4 : RATIO_X2;
      // the wider bus doubles the ratio: one code step up
      if (wide) base = base + 2'd1;
    end
    return base;
  endfunction

endpackage

// File: rtl/cdr_hdr_ctrl.sv
module cdr_hdr_ctrl
  import cdr_pkg::*;
#(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int CNT_W   = $clog2(CMP_IDX + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sofPulse,
  input  logic       wordValid,
  input  logic       wordLast,
  output hdrStrobe_t strobe,
  output logic       ratioValid,
  output logic       headerShort
);

  localparam logic [CNT_W-1:0] ENC_AT = CNT_W'(ENC_IDX);
  localparam logic [CNT_W-1:0] CMP_AT = CNT_W'(CMP_IDX);

  hdrState_e        state;
  logic [CNT_W-1:0] count;
  logic             accept;

  always_comb begin
    accept        = (state == ST_COLLECT) && wordValid && !sofPulse;
    strobe.clear  = sofPulse;
    strobe.capEnc = accept && (count == ENC_AT);
    strobe.capCmp = accept && (count == CMP_AT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      count <= '0;
    end else if (sofPulse) begin
      state <= ST_COLLECT;
      count <= '0;
    end else if (accept) begin
      if (count == CMP_AT) begin
        state <= ST_DONE;
      end else begin
        if (wordLast) state <= ST_SHORT;
        count <= count + 1'b1;
      end
    end
  end

  assign ratioValid  = (state == ST_DONE);
  assign headerShort = (state == ST_SHORT);

  // R8: counter never passes the last header index
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CMP_AT);

  // R8: decision only follows an accepted word
  a_r8_rise_after_word: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ratioValid) |-> $past(wordValid));

  // R8: valid holds until the next image
  a_r8_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid && !sofPulse |=> ratioValid);

  // R9: short error holds until the next image
  a_r9_short_hold: assert property (@(posedge clk) disable iff (!rstN)
    headerShort && !sofPulse |=> headerShort);

  // R9: outcomes are exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ratioValid && headerShort));

  // R11: start of image clears both outcomes
  a_r11_sof_clears: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |=> !ratioValid && !headerShort);

endmodule

// File: rtl/cdr_hdr_dp.sv
module cdr_hdr_dp
  import cdr_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int ENC_LO  = 2,
  parameter int ENC_HI  = 3,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdrStrobe_t        strobe,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wideSel,
  input  logic              ratioValid,
  output logic [1:0]        ratioCode
);

  logic encFlag;
  logic cmpFlag;
  logic wideReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      encFlag <= 1'b0;
      cmpFlag <= 1'b0;
      wideReg <= 1'b0;
    end else if (strobe.clear) begin
      encFlag <= 1'b0;
      cmpFlag <= 1'b0;
      wideReg <= wideSel;
    end else begin
      if (strobe.capEnc) encFlag <= |wordData[ENC_HI:ENC_LO];
      if (strobe.capCmp) cmpFlag <= ~wordData[CMP_BIT];
    end
  end

  assign ratioCode = ratioValid ? calcRatio(encFlag, cmpFlag, wideReg) : RATIO_X1;

  // R5: a narrow bus never reaches x8
  a_r5_narrow_no_x8: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid && !wideReg |-> ratioCode != RATIO_X8);

  // R8: code is steady while valid stays up
  a_r8_code_stable: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid && $past(ratioValid) |-> $stable(ratioCode));

  // R7: width register moves only on a start pulse
  a_r7_width_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> $stable(wideReg));

endmodule

// File: rtl/cdr_hdr_top.sv
module cdr_hdr_top
  import cdr_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LO  = 2,
  parameter int ENC_HI  = 3,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sofPulse,
  input  logic              wideSel,
  input  logic              wordValid,
  input  logic              wordLast,
  input  logic [WORD_W-1:0] wordData,
  output logic [1:0]        ratioCode,
  output logic              ratioValid,
  output logic              headerShort
);

  localparam int CNT_W = $clog2(CMP_IDX + 1);

  hdrStrobe_t strobe;

  cdr_hdr_ctrl #(
    .ENC_IDX(ENC_IDX),
    .CMP_IDX(CMP_IDX),
    .CNT_W  (CNT_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sofPulse   (sofPulse),
    .wordValid  (wordValid),
    .wordLast   (wordLast),
    .strobe     (strobe),
    .ratioValid (ratioValid),
    .headerShort(headerShort)
  );

  cdr_hdr_dp #(
    .WORD_W (WORD_W),
    .ENC_LO (ENC_LO),
    .ENC_HI (ENC_HI),
    .CMP_BIT(CMP_BIT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wordData  (wordData),
    .wideSel   (wideSel),
    .ratioValid(ratioValid),
    .ratioCode (ratioCode)
  );

endmodule

// File: tb/tb_cdr_hdr_top.sv
module tb_cdr_hdr_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sofPulse = 1'b0;
  logic        wideSel = 1'b0;
  logic        wordValid = 1'b0;
  logic        wordLast = 1'b0;
  logic [31:0] wordData = '0;
  logic [1:0]  ratioCode;
  logic        ratioValid;
  logic        headerShort;

  int errors = 0;
  int checks = 0;
  int cycCnt = 0;

  typedef struct packed {
    logic       exShort;
    logic [1:0] exRatio;
    logic [31:0] exCyc;
  } expItem_t;

  expItem_t expQ[$];
  logic seenPrev = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) cycCnt <= cycCnt + 1;

  cdr_hdr_top dut (
    .clk(clk), .rstN(rstN), .sofPulse(sofPulse), .wideSel(wideSel),
    .wordValid(wordValid), .wordLast(wordLast), .wordData(wordData),
    .ratioCode(ratioCode), .ratioValid(ratioValid), .headerShort(headerShort)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycCnt);
    end
  endtask

  // expected code from the requirement tables (R4, R5, R6)
  function automatic logic [1:0] expRatio(input logic wide, input logic enc, input logic cmp);
    case ({wide, enc, cmp})
      3'b000: return 2'd0;
      3'b001: return 2'd2;
      3'b010: return 2'd1;
      3'b011: return 2'd2;
      3'b100: return 2'd0;
      3'b101: return 2'd3;
      3'b110: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [31:0] patt(input int i);
    return (i * 32'h0100_0193) ^ 32'hA5A5_0F0F;
  endfunction

  // monitor: pops one expected item on each rise of an outcome
  always @(negedge clk) begin
    if (rstN) begin
      logic cur;
      cur = ratioValid || headerShort;
      if (cur && !seenPrev) begin
        if (expQ.size() == 0) begin
          check("R10 unexpected outcome", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check("R9 headerShort", int'(headerShort), int'(e.exShort));
          check("R8 ratioValid", int'(ratioValid), int'(!e.exShort));
          check("R5/R6 ratioCode", int'(ratioCode), int'(e.exRatio));
          check("R8 outcome cycle", cycCnt, int'(e.exCyc));
        end
      end
      seenPrev = cur;
    end
  end

  task automatic sendImage(input int nWords, input logic [1:0] encF, input logic cmpB,
                           input logic wide, input bit gaps, input bit flipWide,
                           input bit sofWord);
    expItem_t e;
    @(negedge clk);
    sofPulse = 1'b1; wideSel = wide; wordValid = sofWord; wordData = '0; wordLast = 1'b0;
    @(negedge clk);
    sofPulse = 1'b0; wordValid = 1'b0;
    if (flipWide) wideSel = ~wide;
    // R11: outcomes cleared one cycle after the pulse
    check("R11 valid cleared", int'(ratioValid), 0);
    check("R11 short cleared", int'(headerShort), 0);
    for (int i = 0; i < nWords; i++) begin
      if (gaps && (i % 3 == 1)) begin
        wordValid = 1'b0; wordData = '1; wordLast = 1'b1;
        @(negedge clk);
      end
      wordValid = 1'b1;
      wordData  = patt(i);
      if (i == 69)  wordData[3:2] = encF;
      if (i == 229) wordData[1]   = cmpB;
      wordLast = (i == nWords - 1);
      if (i == 229 || (nWords < 230 && i == nWords - 1)) begin
        e.exShort = (nWords < 230);
        e.exRatio = e.exShort ? 2'd0 : expRatio(wide, |encF, !cmpB);
        e.exCyc   = 32'(cycCnt + 1);
        expQ.push_back(e);
      end
      @(negedge clk);
    end
    wordValid = 1'b0; wordLast = 1'b0;
  endtask

  // feed ignored words and confirm outputs are held (R8, R9, R10)
  task automatic holdCheck(input logic exValid, input logic exShort, input logic [1:0] exCode);
    for (int k = 0; k < 6; k++) begin
      wordValid = 1'b1; wordLast = 1'b1; wordData = 32'h0000_0002 ^ 32'(k);
      wideSel = ~wideSel;
      @(negedge clk);
      check("R8 valid held", int'(ratioValid), int'(exValid));
      check("R9 short held", int'(headerShort), int'(exShort));
      check("R10 code held", int'(ratioCode), int'(exCode));
    end
    wordValid = 1'b0; wordLast = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ratioValid", int'(ratioValid), 0);
    check("R1 headerShort", int'(headerShort), 0);
    check("R1 ratioCode", int'(ratioCode), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R10: words before any start pulse are ignored
    wordValid = 1'b1; wordLast = 1'b1; wordData = '1;
    repeat (4) @(negedge clk);
    wordValid = 1'b0; wordLast = 1'b0;
    @(negedge clk);
    check("R10 pre-sof short", int'(headerShort), 0);
    check("R10 pre-sof valid", int'(ratioValid), 0);

    // R4 R5 R6 R2 R3: all width/flag combinations
    for (int w = 0; w < 2; w++) begin
      for (int f = 0; f < 4; f++) begin
        logic [1:0] encF;
        logic cmpB;
        encF = (f[1]) ? 2'(1 + w + (f % 2)) : 2'd0;  // values 1..3 exercise R2
        cmpB = ~f[0];                                  // bit 1 low means compressed (R3)
        sendImage(240, encF, cmpB, w[0], 1'b0, 1'b0, 1'b0);
        holdCheck(1'b1, 1'b0, expRatio(w[0], |encF, !cmpB));
      end
    end

    // R7: width flips after the pulse
    sendImage(230, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    holdCheck(1'b1, 1'b0, 2'd2);
    sendImage(230, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    holdCheck(1'b1, 1'b0, 2'd2);

    // R10: gaps with garbage and stray last flag; word in pulse cycle
    sendImage(235, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    holdCheck(1'b1, 1'b0, 2'd2);
    sendImage(232, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    holdCheck(1'b1, 1'b0, 2'd2);

    // R9: short images and the boundary
    sendImage(100, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    holdCheck(1'b0, 1'b1, 2'd0);
    sendImage(229, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    holdCheck(1'b0, 1'b1, 2'd0);
    sendImage(230, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    holdCheck(1'b1, 1'b0, 2'd0);

    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule